// File: doc/BRIEF.md
# Embedded Transfer Length Extractor

This block watches the byte stream of an OUT endpoint while a transfer arrives one packet after another. A programmable byte offset, counted from the first payload byte of the transfer, says where a 16-bit message length sits inside the data. The block captures the less significant length byte at that offset and the more significant byte at the following position. The two bytes form the upper half of a descriptor's buffer length word. Each byte has its own captured flag.

The offset count does not restart at packet boundaries, so the two length bytes may fall in different packets. A separate output reports when that happens. Once both bytes are held, extraction stops and a one-cycle done pulse is given. If the transfer ends before the second byte arrives, a length-incomplete error is raised. A start-of-transfer pulse resets everything for the next transfer. Transfers on IN endpoints are never examined.

Top module: `xfer_len_extract`

## Requirements
- R1: A transfer whose start pulse comes with `is_out`=0 (an IN endpoint) captures nothing. Both flags, `done`, `len_err`, `len_split` and `dlen_upper` stay 0 until the next start pulse.
- R2: The byte position counts accepted bytes (`byte_vld`=1) starting at 0 for the first byte after the start pulse. Idle cycles do not advance it. An offset of 0 selects that first byte.
- R3: The byte at position `len_ofs` is stored in `dlen_upper[7:0]` (bits 23:16 of the descriptor length word). `lo_got` reads 1 in the cycle after that byte is presented.
- R4: The byte at position `len_ofs`+1 is stored in `dlen_upper[15:8]` (bits 31:24 of the descriptor length word). `hi_got` is set in the cycle after that byte, and `hi_got` is never 1 while `lo_got` is 0.
- R5: Once both flags are set, later bytes change neither the flags nor `dlen_upper` until a start pulse.
- R6: A start pulse clears both flags, `dlen_upper`, `len_err`, `len_split` and the byte position. A byte presented in the same cycle as the start pulse is ignored.
- R7: The byte position keeps counting across `pkt_end`. `len_split` is 1 after the high byte is captured if a `pkt_end` came with the low byte or later, but before the high byte. Otherwise it is 0.
- R8: `done` is a one-cycle pulse in the first cycle in which `hi_got` reads 1.
- R9: `xfer_end` during an OUT transfer before the high byte is captured sets `len_err` from the next cycle until the next start pulse. A byte in the same cycle as `xfer_end` is still processed first. Bytes after `xfer_end` are ignored.
- R10: The largest offset (all ones in `len_ofs`) still finds the high byte at offset+1. The byte position never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sot | input | 1 | Start-of-transfer pulse |
| is_out | input | 1 | Endpoint direction at start: 1 = OUT |
| len_ofs | input | OFS_W | Byte offset of the length field |
| byte_vld | input | 1 | A payload byte is present |
| byte_data | input | 8 | Payload byte |
| pkt_end | input | 1 | Last byte of a packet (or boundary marker) |
| xfer_end | input | 1 | Transfer finished |
| dlen_upper | output | 16 | Extracted length, descriptor length bits 31:16 |
| lo_got | output | 1 | Low length byte captured |
| hi_got | output | 1 | High length byte captured |
| done | output | 1 | Pulse when extraction completes |
| len_err | output | 1 | Transfer ended before the length was complete |
| len_split | output | 1 | Length bytes fell in different packets |

## Verification
Suppose the byte position counter drifts: it misses a byte, counts an idle cycle, or restarts at a packet boundary. The wrong value then shows up in `dlen_upper` in the cycle after the offset byte. This is checked at that exact cycle, not only at the end of the transfer. Suppose instead the control state is wrong. That shows as a missing or doubled `done` pulse, a flag set on an IN endpoint, a `len_err` that appears without `xfer_end`, or captured bytes that change after completion. Each of these is visible within one cycle of its cause, and the checks look there.

// File: rtl/xle_pkg.sv
package xle_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SEEK, ST_FULL} xfer_st_e;

  // true when the running byte position equals offset + step
  function automatic logic at_pos(input logic [31:0] pos, input logic [31:0] ofs,
                                  input logic [31:0] step);
    return pos == (ofs + step);
  endfunction

  // saturating increment for the position counter
  function automatic logic [31:0] sat_inc(input logic [31:0] v, input logic [31:0] vmax);
    return (v == vmax) ? v : v + 32'd1;
  endfunction
endpackage

// File: rtl/xle_ofs_cnt.sv
module xle_ofs_cnt #(
  parameter int OFS_W = 16,
  localparam int CNT_W = OFS_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  input  logic [OFS_W-1:0] ofs,
  output logic             hit_lo,
  output logic             hit_hi
);
  localparam logic [31:0] CNT_MAX = 32'((64'd1 << CNT_W) - 64'd1);

  logic [CNT_W-1:0] pos_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pos_q <= '0;
    else if (clr)    pos_q <= '0;
    else if (adv)    pos_q <= CNT_W'(xle_pkg::sat_inc(32'(pos_q), CNT_MAX));
  end

  always_comb begin
    hit_lo = xle_pkg::at_pos(32'(pos_q), 32'(ofs), 32'd0);
    hit_hi = xle_pkg::at_pos(32'(pos_q), 32'(ofs), 32'd1);
  end

  AST_POS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !adv) |=> $stable(pos_q)); // R2
  AST_POS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (pos_q == '0)); // R6
endmodule

// File: rtl/xle_len_cap.sv
module xle_len_cap (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        take_lo,
  input  logic        take_hi,
  input  logic [7:0]  din,
  output logic [15:0] len_q,
  output logic        lo_flag,
  output logic        hi_flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q   <= '0;
      lo_flag <= 1'b0;
      hi_flag <= 1'b0;
    end else if (clr) begin
      len_q   <= '0;
      lo_flag <= 1'b0;
      hi_flag <= 1'b0;
    end else begin
      if (take_lo) begin
        len_q[7:0] <= din;
        lo_flag    <= 1'b1;
      end
      if (take_hi && lo_flag) begin
        len_q[15:8] <= din;
        hi_flag     <= 1'b1;
      end
    end
  end

  AST_HI_NEEDS_LO: assert property (@(posedge clk) disable iff (!rst_n)
    hi_flag |-> lo_flag); // R4
  AST_LO_FROM_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lo_flag) |-> $past(take_lo)); // R3
endmodule

// File: rtl/xle_xfer_ctl.sv
module xle_xfer_ctl (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sot,
  input  logic              is_out,
  input  logic              xfer_end,
  input  logic              byte_vld,
  input  logic              pkt_end,
  input  logic              hit_lo,
  input  logic              hit_hi,
  input  logic              lo_flag,
  output xle_pkg::xfer_st_e st,
  output logic              adv,
  output logic              take_lo,
  output logic              take_hi,
  output logic              done,
  output logic              err,
  output logic              split
);
  import xle_pkg::*;

  xfer_st_e st_q;
  logic     bnd_q;
  logic     bnd_now;

  assign st      = st_q;
  assign adv     = (st_q == ST_SEEK) && byte_vld && !sot;
  assign take_lo = adv && hit_lo;
  assign take_hi = adv && hit_hi && lo_flag;
  // a boundary between the low byte (inclusive) and the high byte (exclusive)
  assign bnd_now = (st_q == ST_SEEK) && !sot && pkt_end && (lo_flag || take_lo) && !take_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      bnd_q <= 1'b0;
      done  <= 1'b0;
      err   <= 1'b0;
      split <= 1'b0;
    end else if (sot) begin
      st_q  <= is_out ? ST_SEEK : ST_IDLE;
      bnd_q <= 1'b0;
      done  <= 1'b0;
      err   <= 1'b0;
      split <= 1'b0;
    end else begin
      done <= take_hi;
      if (bnd_now) bnd_q <= 1'b1;
      if (take_hi) split <= bnd_q;
      if (xfer_end) begin
        st_q <= ST_IDLE;
        if ((st_q == ST_SEEK) && !take_hi) err <= 1'b1;
      end else if (take_hi) begin
        st_q <= ST_FULL;
      end
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(xfer_end)); // R9
  AST_IDLE_NO_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |-> !adv); // R1
endmodule

// File: rtl/xfer_len_extract.sv
module xfer_len_extract #(
  parameter int OFS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sot,
  input  logic             is_out,
  input  logic [OFS_W-1:0] len_ofs,
  input  logic             byte_vld,
  input  logic [7:0]       byte_data,
  input  logic             pkt_end,
  input  logic             xfer_end,
  output logic [15:0]      dlen_upper,
  output logic             lo_got,
  output logic             hi_got,
  output logic             done,
  output logic             len_err,
  output logic             len_split
);
  xle_pkg::xfer_st_e st;
  logic adv, take_lo, take_hi, hit_lo, hit_hi;

  xle_ofs_cnt #(.OFS_W(OFS_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(sot), .adv(adv), .ofs(len_ofs),
    .hit_lo(hit_lo), .hit_hi(hit_hi)
  );

  xle_xfer_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .sot(sot), .is_out(is_out), .xfer_end(xfer_end),
    .byte_vld(byte_vld), .pkt_end(pkt_end), .hit_lo(hit_lo), .hit_hi(hit_hi),
    .lo_flag(lo_got), .st(st), .adv(adv), .take_lo(take_lo), .take_hi(take_hi),
    .done(done), .err(len_err), .split(len_split)
  );

  xle_len_cap u_cap (
    .clk(clk), .rst_n(rst_n), .clr(sot), .take_lo(take_lo), .take_hi(take_hi),
    .din(byte_data), .len_q(dlen_upper), .lo_flag(lo_got), .hi_flag(hi_got)
  );

  AST_DONE_AT_HI: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (hi_got && !$past(hi_got))); // R8
  AST_SOT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    sot |=> (!lo_got && !hi_got && !len_err && !len_split && dlen_upper == 16'h0)); // R6
  AST_FULL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_got && !sot) |=> (hi_got && $stable(dlen_upper))); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == xle_pkg::ST_IDLE && !sot) |=> $stable(dlen_upper)); // R1
endmodule

// File: tb/test_xfer_len_extract.sv
module test_xfer_len_extract;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sot = 1'b0, is_out = 1'b0, byte_vld = 1'b0, pkt_end = 1'b0, xfer_end = 1'b0;
  logic [15:0] len_ofs = '0;
  logic [7:0]  byte_data = '0;
  logic [15:0] dlen_upper;
  logic        lo_got, hi_got, done, len_err, len_split;

  int n_chk = 0, n_err = 0, cyc = 0, done_cnt = 0;
  logic prev_hi = 1'b0;

  always #5 clk = ~clk;

  xfer_len_extract i_xfer_len_extract (
    .clk(clk), .rst_n(rst_n), .sot(sot), .is_out(is_out), .len_ofs(len_ofs),
    .byte_vld(byte_vld), .byte_data(byte_data), .pkt_end(pkt_end), .xfer_end(xfer_end),
    .dlen_upper(dlen_upper), .lo_got(lo_got), .hi_got(hi_got), .done(done),
    .len_err(len_err), .len_split(len_split)
  );

  function automatic logic [7:0] pay(input int idx, input int salt);
    return 8'((idx * 37) + (salt * 11) + (idx >> 8) + 1);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  // R8: done pulse must coincide with the first cycle hi_got reads 1
  always @(negedge clk) begin
    if (rst_n && done) begin
      done_cnt++;
      chk(hi_got && !prev_hi, "R8 done with first hi_got", {30'd0, prev_hi, hi_got}, 1);
    end
    prev_hi = hi_got;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 195000) begin
      chk(0, "watchdog", cyc, 0);
      summary();
    end
  end

  task automatic observe(input int last, input bit out, input int ofs, input int salt);
    if (last == -1) begin
      chk(!lo_got && !hi_got && !len_err && !len_split && dlen_upper == 16'h0,
          "R6 cleared after start", {lo_got, hi_got, len_err, len_split, dlen_upper}, 0);
    end
    if (out && last == ofs) begin
      chk(lo_got && dlen_upper[7:0] == pay(ofs, salt), "R3 low byte timing",
          {lo_got, dlen_upper[7:0]}, {1'b1, pay(ofs, salt)});
    end
    if (out && last == ofs + 1) begin
      chk(hi_got && done && dlen_upper[15:8] == pay(ofs + 1, salt), "R4 high byte timing",
          {hi_got, done, dlen_upper[15:8]}, {2'b11, pay(ofs + 1, salt)});
    end
  endtask

  task automatic run_xfer(input bit out, input int ofs, input int nbytes, input int pmax,
                          input bit gaps, input bit junk, input bit term, input int salt);
    int  plen, ppos;
    bit  split_exp = 0;
    bit  lo_exp, hi_exp;
    logic [15:0] dl_exp;
    @(negedge clk);
    done_cnt  = 0;
    sot       = 1'b1;
    is_out    = out;
    len_ofs   = 16'(ofs);
    byte_vld  = junk;
    byte_data = 8'hEE;
    pkt_end   = 1'b0;
    xfer_end  = 1'b0;
    plen = 1 + int'($urandom % pmax);
    ppos = 0;
    for (int i = 0; i < nbytes; i++) begin
      @(negedge clk);
      sot = 1'b0;
      observe(i - 1, out, ofs, salt);
      if (gaps && ($urandom % 4 == 0)) begin
        byte_vld = 1'b0; pkt_end = 1'b0; xfer_end = 1'b0; byte_data = 8'h5A;
        @(negedge clk);
      end
      byte_vld  = 1'b1;
      byte_data = pay(i, salt);
      pkt_end   = (ppos == plen - 1) || (i == nbytes - 1);
      xfer_end  = term && (i == nbytes - 1);
      if (i == ofs && pkt_end) split_exp = 1;
      if (ppos == plen - 1) begin
        ppos = 0;
        plen = 1 + int'($urandom % pmax);
      end else ppos++;
    end
    @(negedge clk);
    sot = 1'b0;
    observe(nbytes - 1, out, ofs, salt);
    byte_vld = 1'b0; pkt_end = 1'b0;
    xfer_end = term && (nbytes == 0);
    @(negedge clk);
    xfer_end = 1'b0;
    if (term) begin
      // bytes after the end of the transfer must be ignored (R9)
      for (int k = 0; k < 3; k++) begin
        byte_vld = 1'b1; byte_data = pay(ofs + k, salt + 1);
        @(negedge clk);
      end
      byte_vld = 1'b0;
      @(negedge clk);
    end
    lo_exp = out && (ofs < nbytes);
    hi_exp = out && (ofs + 1 < nbytes);
    dl_exp = {hi_exp ? pay(ofs + 1, salt) : 8'h00, lo_exp ? pay(ofs, salt) : 8'h00};
    chk(dlen_upper == dl_exp, out ? "R2 extracted length" : "R1 IN length zero",
        dlen_upper, dl_exp);
    chk(lo_got == lo_exp && hi_got == hi_exp, "R4 flags", {lo_got, hi_got}, {lo_exp, hi_exp});
    chk(len_err == (out && term && !hi_exp), "R9 incomplete error", len_err,
        out && term && !hi_exp);
    chk(len_split == (hi_exp && split_exp), "R7 split across packets", len_split,
        hi_exp && split_exp);
    chk(done_cnt == (hi_exp ? 1 : 0), "R8 done count", done_cnt, hi_exp ? 1 : 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!lo_got && !hi_got && !done && !len_err && dlen_upper == 0, "R6 reset state",
        {lo_got, hi_got, done, len_err}, 0);
    rst_n = 1'b1;
    // R1: IN endpoint
    run_xfer(0, 2, 10, 4, 0, 0, 1, 3);
    // R2/R3: offset 0, single-byte packets so the length splits (R7)
    run_xfer(1, 0, 6, 1, 0, 0, 1, 5);
    // R7: one long packet, no split
    run_xfer(1, 4, 12, 64, 0, 0, 1, 6);
    // R9: transfer ends on the low byte
    run_xfer(1, 3, 4, 8, 0, 0, 1, 7);
    // R9: empty transfer
    run_xfer(1, 0, 0, 1, 0, 0, 1, 8);
    // R9: ends exactly on the high byte -> no error
    run_xfer(1, 5, 7, 3, 0, 0, 1, 9);
    // R6: junk byte in the start cycle, then an unfinished transfer restarted
    run_xfer(1, 0, 5, 2, 0, 1, 1, 10);
    run_xfer(1, 1, 1, 2, 0, 0, 0, 11);
    run_xfer(1, 1, 6, 2, 1, 0, 1, 12);
    // R5/R2: random mix with idle gaps
    for (int t = 0; t < 40; t++) begin
      run_xfer(($urandom % 5) != 0, int'($urandom % 24), int'($urandom % 32),
               1 + int'($urandom % 8), 1'($urandom % 2), 1'($urandom % 2), 1'b1, t + 20);
    end
    // R10: largest offset
    run_xfer(1, 65535, 65538, 64, 0, 0, 1, 99);
    summary();
  end
endmodule